// File: doc/BRIEF.md
# ADC Queue Freeze Controller

This block decides when a queued conversion sequencer stops for a debug halt and what it resumes with afterwards. A bus-level halt request is honoured only while a local enable bit is set. The halt takes effect at once when no queue is converting. When a queue is busy, the halt waits for the end of the current conversion. It also takes effect at once if, during that wait, the active queue's mode is rewritten or queue 2 is aborted.

While halted, the block does four things. It holds the conversion clock prescaler and the periodic timer in reset. It blocks capture of external trigger edges. It freezes the command pointer. If a queue was busy on entry, it exposes a snapshot of that pointer.

Mode writes from software are still accepted during the halt. They reload the resume pointer, so on release the next command comes from the newest mode setting, or else from the saved pointer. A trigger that was pending before the halt stays pending. Conversions are represented by a one-cycle done pulse.

Top module: `adc_freeze_ctrl`

## Requirements
- R1: While `halt_en` is 0, `halt_req` has no effect: `halted` and `halt_pending` stay 0, and the pointer keeps advancing on `conv_done`.
- R2: With `halt_en`=1 and `q_busy`=0 sampled at a clock edge together with `halt_req`=1, `halted` is 1 after that edge.
- R3: With `q_busy`=1, a sampled halt request sets `halt_pending` (and not `halted`) until an edge where `conv_done` is 1 or `q_busy` is 0. After that edge `halted` is 1 and `halt_pending` is 0.
- R4: A `mode_upd` or `q2_abort` pulse sampled while a halt is requested (pending, or in the request cycle) makes `halted` 1 after that edge, without waiting for `conv_done`.
- R5: On entry to the halt, `saved_ptr` takes the pointer value after the entry edge's own update. A `conv_done` in the entry cycle therefore advances it first. `saved_vld` is 1 while halted only if `q_busy` was 1 on entry.
- R6: `pscl_rst`, `ptimer_rst` and `trig_block` are 1 exactly in the cycles where `halted` is 1.
- R7: An `ext_trig` pulse sampled while halted does not set `trig_pend`. A trigger pending before the halt is kept through it. `trig_ack` clears `trig_pend`, and a new trigger in the same cycle wins.
- R8: `conv_done` pulses sampled while halted do not change `cmd_ptr`.
- R9: `mode_wr` loads `mode_ptr` into `cmd_ptr` at any time, including while halted, with priority over a `conv_done` increment. A write during the halt leaves `saved_ptr` unchanged, and `cmd_ptr` keeps the written value after release.
- R10: At the first clock edge where `halt_req` (or `halt_en`) is sampled 0 while halted, `halted` and all hold and block outputs fall.
- R11: `cmd_ptr` increments by one per `conv_done` while `q_busy`=1 and not halted, wrapping from 2^PTR_W-1 to 0.
- R12: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Bus-level debug halt request |
| halt_en | input | 1 | Enable for responding to the halt request |
| q_busy | input | 1 | A queue is currently converting |
| conv_done | input | 1 | Pulse: current conversion finished |
| mode_upd | input | 1 | Pulse: active queue's operating mode rewritten |
| q2_abort | input | 1 | Pulse: queue 2 aborted |
| mode_wr | input | 1 | Software mode write, loads a new start pointer |
| mode_ptr | input | PTR_W | Start pointer carried by the mode write |
| ext_trig | input | 1 | External trigger event pulse |
| trig_ack | input | 1 | Sequencer consumed the pending trigger |
| halted | output | 1 | Block is in the halt state |
| halt_pending | output | 1 | Halt requested, waiting for conversion end |
| pscl_rst | output | 1 | Hold conversion clock prescaler in reset |
| ptimer_rst | output | 1 | Hold periodic/interval timer in reset |
| trig_block | output | 1 | External trigger capture blocked |
| cmd_ptr | output | PTR_W | Command pointer for the next command word |
| saved_ptr | output | PTR_W | Pointer snapshot taken on halt entry |
| saved_vld | output | 1 | Snapshot valid (halted, queue was busy on entry) |
| trig_pend | output | 1 | External trigger pending |

## Verification
Every result is one register away from its cause. A request, done, mode-change or abort sampled at edge n shows on `halted` and `halt_pending` after edge n. The pointer, the snapshot and the trigger flag also change at edge n. The hold and block outputs follow `halted` in the same cycle, with no further delay. The bench drives inputs on the falling edge and lets its reference model step at the rising edge on those same stable inputs. It compares every output on the next falling edge, so each check looks at the cycle right after the edge that was due to change it.

// File: rtl/afc_pkg.sv
package afc_pkg;
    typedef enum logic [1:0] {
        FZ_RUN  = 2'd0,
        FZ_WAIT = 2'd1,
        FZ_HELD = 2'd2
    } fz_state_e;
endpackage

// File: rtl/afc_freeze_fsm.sv
module afc_freeze_fsm
    import afc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt_req,
    input  logic halt_en,
    input  logic q_busy,
    input  logic conv_done,
    input  logic mode_upd,
    input  logic q2_abort,
    output logic halted,
    output logic waiting,
    output logic enter
);
    typedef struct packed {
        fz_state_e st;
    } fsm_s;

    fsm_s r_q, r_d;
    logic eff_req, cut;

    always_comb begin
        eff_req = halt_req & halt_en;
        cut     = conv_done | mode_upd | q2_abort | ~q_busy;
        r_d     = r_q;
        case (r_q.st)
            FZ_RUN:  if (eff_req) r_d.st = cut ? FZ_HELD : FZ_WAIT;
            FZ_WAIT: if (!eff_req) r_d.st = FZ_RUN;
                     else if (cut) r_d.st = FZ_HELD;
            FZ_HELD: if (!eff_req) r_d.st = FZ_RUN;
            default: r_d.st = FZ_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: FZ_RUN};
        else        r_q <= r_d;
    end

    assign halted  = (r_q.st == FZ_HELD);
    assign waiting = (r_q.st == FZ_WAIT);
    assign enter   = (r_d.st == FZ_HELD) && (r_q.st != FZ_HELD);

    AST_EN_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        !halt_en |=> !halted && !waiting); // R1
    AST_IDLE_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && halt_req && halt_en && !q_busy) |=> halted); // R2
    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && halt_req && halt_en && q_busy && !conv_done && !mode_upd && !q2_abort)
        |=> waiting && !halted); // R3
    AST_ABORT_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && halt_req && halt_en && (mode_upd || q2_abort)) |=> halted); // R4
endmodule

// File: rtl/afc_cmd_ptr.sv
module afc_cmd_ptr #(
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halted,
    input  logic             enter,
    input  logic             q_busy,
    input  logic             conv_done,
    input  logic             mode_wr,
    input  logic [PTR_W-1:0] mode_ptr,
    output logic [PTR_W-1:0] cmd_ptr,
    output logic [PTR_W-1:0] saved_ptr,
    output logic             saved_busy
);
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic [PTR_W-1:0] sav;
        logic             vld;
    } ptr_s;

    ptr_s r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (mode_wr)
            r_d.ptr = mode_ptr;
        else if (conv_done && q_busy && !halted)
            r_d.ptr = r_q.ptr + ONE;
        if (enter) begin
            r_d.sav = r_d.ptr;
            r_d.vld = q_busy;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cmd_ptr    = r_q.ptr;
    assign saved_ptr  = r_q.sav;
    assign saved_busy = r_q.vld;

    AST_PTR_STILL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !mode_wr) |=> $stable(cmd_ptr)); // R8
    AST_SNAPSHOT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !enter) |=> $stable(saved_ptr)); // R9
endmodule

// File: rtl/afc_trig_gate.sv
module afc_trig_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic halted,
    input  logic ext_trig,
    input  logic trig_ack,
    output logic trig_pend
);
    typedef struct packed {
        logic pend;
    } trg_s;

    trg_s r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (trig_ack)             r_d.pend = 1'b0;
        if (ext_trig && !halted)  r_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign trig_pend = r_q.pend;

    AST_TRIG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !trig_pend) |=> !trig_pend); // R7
    AST_TRIG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_pend && !trig_ack) |=> trig_pend); // R7
endmodule

// File: rtl/adc_freeze_ctrl.sv
module adc_freeze_ctrl #(
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_req,
    input  logic             halt_en,
    input  logic             q_busy,
    input  logic             conv_done,
    input  logic             mode_upd,
    input  logic             q2_abort,
    input  logic             mode_wr,
    input  logic [PTR_W-1:0] mode_ptr,
    input  logic             ext_trig,
    input  logic             trig_ack,
    output logic             halted,
    output logic             halt_pending,
    output logic             pscl_rst,
    output logic             ptimer_rst,
    output logic             trig_block,
    output logic [PTR_W-1:0] cmd_ptr,
    output logic [PTR_W-1:0] saved_ptr,
    output logic             saved_vld,
    output logic             trig_pend
);
    logic held, enter, sav_busy;

    afc_freeze_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt_req  (halt_req),
        .halt_en   (halt_en),
        .q_busy    (q_busy),
        .conv_done (conv_done),
        .mode_upd  (mode_upd),
        .q2_abort  (q2_abort),
        .halted    (held),
        .waiting   (halt_pending),
        .enter     (enter)
    );

    afc_cmd_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .halted     (held),
        .enter      (enter),
        .q_busy     (q_busy),
        .conv_done  (conv_done),
        .mode_wr    (mode_wr),
        .mode_ptr   (mode_ptr),
        .cmd_ptr    (cmd_ptr),
        .saved_ptr  (saved_ptr),
        .saved_busy (sav_busy)
    );

    afc_trig_gate u_trg (
        .clk       (clk),
        .rst_n     (rst_n),
        .halted    (held),
        .ext_trig  (ext_trig),
        .trig_ack  (trig_ack),
        .trig_pend (trig_pend)
    );

    assign halted     = held;
    assign pscl_rst   = held;
    assign ptimer_rst = held;
    assign trig_block = held;
    assign saved_vld  = held & sav_busy;

    AST_EXIT_PROMPT: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !(halt_req && halt_en)) |=> !halted && !pscl_rst && !trig_block); // R10
    AST_NO_DUAL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !(halted && halt_pending)); // R3
endmodule

// File: tb/adc_freeze_ctrl_tb_top.sv
module adc_freeze_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 6;
    localparam int PMOD = 1 << PW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_req = 0, halt_en = 0, q_busy = 0, conv_done = 0;
    logic mode_upd = 0, q2_abort = 0, mode_wr = 0, ext_trig = 0, trig_ack = 0;
    logic [PW-1:0] mode_ptr = '0;
    logic halted, halt_pending, pscl_rst, ptimer_rst, trig_block, saved_vld, trig_pend;
    logic [PW-1:0] cmd_ptr, saved_ptr;

    int n_run = 0, n_fail = 0;
    string cur_req = "R12";

    int m_st = 0, m_ptr = 0, m_sav = 0, m_vld = 0, m_trig = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_freeze_ctrl #(.PTR_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .halt_en(halt_en),
        .q_busy(q_busy), .conv_done(conv_done), .mode_upd(mode_upd),
        .q2_abort(q2_abort), .mode_wr(mode_wr), .mode_ptr(mode_ptr),
        .ext_trig(ext_trig), .trig_ack(trig_ack), .halted(halted),
        .halt_pending(halt_pending), .pscl_rst(pscl_rst), .ptimer_rst(ptimer_rst),
        .trig_block(trig_block), .cmd_ptr(cmd_ptr), .saved_ptr(saved_ptr),
        .saved_vld(saved_vld), .trig_pend(trig_pend)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit eff, cut, was_held, ent;
        int ns;
        eff = halt_req && halt_en;
        cut = conv_done || mode_upd || q2_abort || !q_busy;
        was_held = (m_st == 2);
        ns = m_st;
        if (!eff) ns = 0;
        else if (m_st == 0 || m_st == 1) ns = cut ? 2 : 1;
        ent = (ns == 2) && !was_held;
        if (mode_wr) m_ptr = int'(mode_ptr);
        else if (conv_done && q_busy && !was_held) m_ptr = (m_ptr + 1) % PMOD;
        if (ent) begin m_sav = m_ptr; m_vld = q_busy; end
        if (trig_ack) m_trig = 0;
        if (ext_trig && !was_held) m_trig = 1;
        m_st = ns;
    endtask

    task automatic compare_all();
        int h;
        h = (m_st == 2);
        chk(cur_req, "halted", halted, h);
        chk(cur_req, "halt_pending", halt_pending, m_st == 1);
        chk("R6", "pscl_rst", pscl_rst, h);
        chk("R6", "ptimer_rst", ptimer_rst, h);
        chk("R6", "trig_block", trig_block, h);
        chk(cur_req, "cmd_ptr", cmd_ptr, m_ptr);
        chk(cur_req, "saved_vld", saved_vld, h && m_vld);
        if (h) chk(cur_req, "saved_ptr", saved_ptr, m_sav);
        chk(cur_req, "trig_pend", trig_pend, m_trig);
    endtask

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            if (rst_n) model_step();
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic pulse_done();
        conv_done = 1; cyc(); conv_done = 0;
    endtask

    task automatic write_mode(int p);
        mode_wr = 1; mode_ptr = PW'(p); cyc(); mode_wr = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        cur_req = "R12";
        cyc(2);
        @(negedge clk); rst_n = 1;
        cyc();
        chk("R12", "halted after reset", halted, 0);
        chk("R12", "cmd_ptr after reset", cmd_ptr, 0);

        // R11: wrap of the command pointer
        cur_req = "R11";
        q_busy = 1;
        write_mode(PMOD - 2);
        pulse_done(); pulse_done(); pulse_done();
        chk("R11", "wrapped cmd_ptr", cmd_ptr, 1);

        // R1: request ignored while disabled
        cur_req = "R1";
        halt_en = 0; halt_req = 1;
        cyc(2); pulse_done(); cyc();
        chk("R1", "halted with enable clear", halted, 0);
        chk("R1", "pointer still moves", cmd_ptr, 2);
        halt_req = 0;

        // R2: idle queue, immediate halt
        cur_req = "R2";
        halt_en = 1; q_busy = 0;
        halt_req = 1; cyc();
        chk("R2", "immediate halt", halted, 1);
        chk("R2", "no snapshot when idle", saved_vld, 0);
        cur_req = "R6"; cyc(3);
        cur_req = "R10";
        halt_req = 0; cyc();
        chk("R10", "released", halted, 0);
        chk("R10", "prescaler released", pscl_rst, 0);

        // R3: busy queue waits for conversion end
        cur_req = "R3";
        q_busy = 1; halt_req = 1;
        cyc(3);
        chk("R3", "waiting", halt_pending, 1);
        chk("R3", "not yet halted", halted, 0);
        pulse_done();
        chk("R3", "halted after done", halted, 1);
        chk("R5", "snapshot after done", saved_ptr, 3);
        chk("R5", "snapshot valid", saved_vld, 1);

        // R8: done while held does not move pointer
        cur_req = "R8";
        pulse_done(); pulse_done();
        chk("R8", "pointer held", cmd_ptr, 3);

        // R9: mode write during halt
        cur_req = "R9";
        write_mode(20);
        chk("R9", "cmd_ptr loaded", cmd_ptr, 20);
        chk("R9", "snapshot kept", saved_ptr, 3);
        halt_req = 0; cyc();
        chk("R9", "resume pointer", cmd_ptr, 20);

        // R3: queue going idle while waiting
        cur_req = "R3";
        halt_req = 1; cyc(2);
        q_busy = 0; cyc();
        chk("R3", "halt when queue goes idle", halted, 1);
        halt_req = 0; q_busy = 1; cyc();

        // R4: mode update mid-conversion
        cur_req = "R4";
        halt_req = 1; cyc(2);
        mode_upd = 1; cyc(); mode_upd = 0;
        chk("R4", "halt on mode update", halted, 1);
        halt_req = 0; cyc();
        // R4: abort in the request cycle
        halt_req = 1; q2_abort = 1; cyc(); q2_abort = 0;
        chk("R4", "halt on abort", halted, 1);
        halt_req = 0; cyc();

        // R5: done in the same cycle as the request
        cur_req = "R5";
        write_mode(9);
        halt_req = 1; conv_done = 1; cyc(); conv_done = 0;
        chk("R5", "same-cycle done counted", saved_ptr, 10);
        halt_req = 0; cyc();

        // R7: trigger handling
        cur_req = "R7";
        ext_trig = 1; cyc(); ext_trig = 0;
        q_busy = 0; halt_req = 1; cyc();
        chk("R7", "pending kept into halt", trig_pend, 1);
        trig_ack = 1; cyc(); trig_ack = 0;
        ext_trig = 1; cyc(2); ext_trig = 0;
        chk("R7", "trigger dropped while held", trig_pend, 0);
        halt_req = 0; cyc();
        ext_trig = 1; trig_ack = 1; cyc(); ext_trig = 0; trig_ack = 0;
        chk("R7", "new trigger beats ack", trig_pend, 1);
        trig_ack = 1; cyc(); trig_ack = 0;

        // R10: enable dropped while held
        cur_req = "R10";
        halt_req = 1; cyc();
        halt_en = 0; cyc();
        chk("R10", "exit on enable clear", halted, 0);
        halt_req = 0; cyc(2);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule